// File: doc/BRIEF.md
# Table-Driven HD Sync Pattern Generator

This block produces the per-pixel sync level code for a high-definition output raster. The raster is not built from fixed counters. It is described by three small tables that software loads. A line-order table lists, one entry per line, which line shape to use. A shape table gives, for each of sixteen line shapes, the index of its first segment. A segment table gives each segment a length and a two-bit level. While `run` is high, the walker steps pixel by pixel through these tables. It emits the current level together with markers for line start and frame start. A downstream converter turns the level codes into tri-level or bi-level analog sync.

The tables are loaded and read back through a byte-wide port. The port has one address pointer per table. Each pointer advances after every byte read or written, so a block of bytes streams into consecutive locations. Reads also move the pointers, so software clears all pointers before it starts a new series of writes.

Top module: `hdsync_seqgen`

## Requirements
- R1: `level` carries the code of the segment now playing, with 0 = zero/blank, 1 = negative sync, 2 = positive sync and 3 = black.
- R2: A segment whose stored duration is D holds its level for exactly D+1 consecutive pixels, for any D up to the full 13-bit range.
- R3: Within a line, segments play in ascending index order. The first is the one named by the line shape, and the line ends after the first segment whose end-of-line flag (bit 7 of its upper byte) is set.
- R4: After a line ends, the walker moves to the next line-order entry. It wraps to entry 0 after an entry whose last flag (bit 7) is set, or after entry 15.
- R5: `line_start` is high on the first pixel of every line. `frame_start` is high on the first pixel of line-order entry 0, and only when `line_start` is also high.
- R6: Writes take the table selected by `tbl_sel`. Select 0 is the line-order table: type in bits 3:0, last flag in bit 7. Select 1 is the shape table: first segment in bits 4:0. Select 2 is the segment table, two bytes per segment: the first byte holds duration bits 7:0; the second holds duration bits 12:8 in bits 4:0, the level in bits 6:5 and end-of-line in bit 7. The selected pointer advances by one after each byte.
- R7: An access with select 3 returns all three pointers to zero. A read returns the byte at the selected pointer in the same layout as R6 (unused bits zero) and then advances that pointer.
- R8: While reset is asserted, or from the second clock edge after `run` goes low, `level` is blank and both markers are low. After `run` rises again, the raster restarts at entry 0.
- R9: When `run` is sampled high at clock edge k, the first pixel of entry 0 appears on the outputs after edge k+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run | input | 1 | Raster enable; low holds the walker idle and the output blank |
| tbl_sel | input | 2 | Table select: 0 line order, 1 line shape, 2 segment, 3 pointer clear |
| wr_en | input | 1 | Write `wr_data` to the selected table and advance its pointer |
| rd_en | input | 1 | Advance the selected pointer after reading `rd_data` |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Byte at the selected pointer |
| level | output | 2 | Sync level code of the current pixel |
| line_start | output | 1 | First pixel of a line |
| frame_start | output | 1 | First pixel of a frame |

## Verification
A wrong segment counter shows at the ports as a level run that is one pixel too long or too short. This appears inside the first line of the raster. A bad segment or line-order pointer moves the `line_start` and `frame_start` markers away from their expected pixels, or plays the wrong level code, within one frame of at most a few hundred pixels. A faulty write pointer puts bytes at the wrong addresses. That shows in the readback of the first few entries, and in the played raster right after loading.

// File: rtl/hsg_pkg.sv
package hsg_pkg;

  typedef enum logic [1:0] {
    LVL_ZERO  = 2'd0,
    LVL_NEG   = 2'd1,
    LVL_POS   = 2'd2,
    LVL_BLACK = 2'd3
  } lvl_e;

  typedef enum logic [1:0] {
    SEL_SEQ  = 2'd0,
    SEL_TYPE = 2'd1,
    SEL_SEG  = 2'd2,
    SEL_CLR  = 2'd3
  } tsel_e;

endpackage

// File: rtl/hsg_wr_ctrl.sv
module hsg_wr_ctrl
  import hsg_pkg::*;
#(
  parameter int SEQ_DEPTH = 16,
  parameter int TYPE_CNT  = 16,
  parameter int SEG_DEPTH = 32,
  localparam int SQW = $clog2(SEQ_DEPTH),
  localparam int TYW = $clog2(TYPE_CNT),
  localparam int SPW = $clog2(SEG_DEPTH) + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic           rd_en,
  input  logic [1:0]     sel,
  output logic [SQW-1:0] seq_ptr,
  output logic [TYW-1:0] typ_ptr,
  output logic [SPW-1:0] seg_ptr,
  output logic           seq_we,
  output logic           typ_we,
  output logic           seg_we
);

  tsel_e          sel_e;
  logic           step;
  logic [SQW-1:0] seq_ptr_d;
  logic [TYW-1:0] typ_ptr_d;
  logic [SPW-1:0] seg_ptr_d;

  assign sel_e = tsel_e'(sel);
  assign step  = wr_en | rd_en;

  assign seq_we = wr_en && (sel_e == SEL_SEQ);
  assign typ_we = wr_en && (sel_e == SEL_TYPE);
  assign seg_we = wr_en && (sel_e == SEL_SEG);

  always_comb begin
    seq_ptr_d = seq_ptr;
    typ_ptr_d = typ_ptr;
    seg_ptr_d = seg_ptr;
    if (step) begin
      unique case (sel_e)
        SEL_SEQ:  seq_ptr_d = seq_ptr + SQW'(1);
        SEL_TYPE: typ_ptr_d = typ_ptr + TYW'(1);
        SEL_SEG:  seg_ptr_d = seg_ptr + SPW'(1);
        SEL_CLR: begin
          seq_ptr_d = '0;
          typ_ptr_d = '0;
          seg_ptr_d = '0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_ptr <= '0;
      typ_ptr <= '0;
      seg_ptr <= '0;
    end else if (step) begin
      seq_ptr <= seq_ptr_d;
      typ_ptr <= typ_ptr_d;
      seg_ptr <= seg_ptr_d;
    end
  end

  AST_SEQ_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel_e == SEL_SEQ) |=> seq_ptr == $past(seq_ptr) + SQW'(1)); // R6

  AST_SEG_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && sel_e == SEL_SEG) |=> seg_ptr == $past(seg_ptr) + SPW'(1)); // R7

  AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (step && sel_e == SEL_CLR) |=> (seq_ptr == '0 && typ_ptr == '0 && seg_ptr == '0)); // R7

endmodule

// File: rtl/hsg_tables.sv
module hsg_tables #(
  parameter int SEQ_DEPTH = 16,
  parameter int TYPE_CNT  = 16,
  parameter int SEG_DEPTH = 32,
  parameter int DUR_W     = 13,
  localparam int SQW = $clog2(SEQ_DEPTH),
  localparam int TYW = $clog2(TYPE_CNT),
  localparam int SGW = $clog2(SEG_DEPTH),
  localparam int SPW = SGW + 1,
  localparam int DHW = DUR_W - 8
) (
  input  logic             clk,
  input  logic             seq_we,
  input  logic             typ_we,
  input  logic             seg_we,
  input  logic [SQW-1:0]   seq_ptr,
  input  logic [TYW-1:0]   typ_ptr,
  input  logic [SPW-1:0]   seg_ptr,
  input  logic [7:0]       wdata,
  input  logic [1:0]       rd_sel,
  output logic [7:0]       rd_data,
  input  logic [SQW-1:0]   seq_cur_addr,
  output logic             seq_cur_last,
  input  logic [SQW-1:0]   seq_nxt_addr,
  output logic [SGW-1:0]   nxt_start,
  input  logic [SGW-1:0]   seg_addr,
  output logic [DUR_W-1:0] seg_dur,
  output logic [1:0]       seg_lvl,
  output logic             seg_eol
);

  logic             seq_last_m [SEQ_DEPTH];
  logic [TYW-1:0]   seq_type_m [SEQ_DEPTH];
  logic [SGW-1:0]   typ_start_m[TYPE_CNT];
  logic [DUR_W-1:0] seg_dur_m  [SEG_DEPTH];
  logic [1:0]       seg_lvl_m  [SEG_DEPTH];
  logic             seg_eol_m  [SEG_DEPTH];

  logic [SGW-1:0]   seg_widx;
  assign seg_widx = seg_ptr[SPW-1:1];

  always_ff @(posedge clk) begin
    if (seq_we) begin
      seq_last_m[seq_ptr] <= wdata[7];
      seq_type_m[seq_ptr] <= wdata[TYW-1:0];
    end
    if (typ_we) begin
      typ_start_m[typ_ptr] <= wdata[SGW-1:0];
    end
    if (seg_we) begin
      if (!seg_ptr[0]) begin
        seg_dur_m[seg_widx][7:0] <= wdata;
      end else begin
        seg_dur_m[seg_widx][DUR_W-1:8] <= wdata[DHW-1:0];
        seg_lvl_m[seg_widx]            <= wdata[6:5];
        seg_eol_m[seg_widx]            <= wdata[7];
      end
    end
  end

  // walker lookups: current line's last flag, next line's first segment
  assign seq_cur_last = seq_last_m[seq_cur_addr];
  assign nxt_start    = typ_start_m[seq_type_m[seq_nxt_addr]];
  assign seg_dur      = seg_dur_m[seg_addr];
  assign seg_lvl      = seg_lvl_m[seg_addr];
  assign seg_eol      = seg_eol_m[seg_addr];

  // software readback in write layout
  always_comb begin
    rd_data = '0;
    unique case (rd_sel)
      2'd0: begin
        rd_data[7]       = seq_last_m[seq_ptr];
        rd_data[TYW-1:0] = seq_type_m[seq_ptr];
      end
      2'd1: rd_data[SGW-1:0] = typ_start_m[typ_ptr];
      2'd2: begin
        if (!seg_ptr[0]) begin
          rd_data = seg_dur_m[seg_widx][7:0];
        end else begin
          rd_data[DHW-1:0] = seg_dur_m[seg_widx][DUR_W-1:8];
          rd_data[6:5]     = seg_lvl_m[seg_widx];
          rd_data[7]       = seg_eol_m[seg_widx];
        end
      end
      default: rd_data = '0;
    endcase
  end

endmodule

// File: rtl/hsg_walker.sv
module hsg_walker
  import hsg_pkg::*;
#(
  parameter int SEQ_DEPTH = 16,
  parameter int SEG_DEPTH = 32,
  parameter int DUR_W     = 13,
  localparam int SQW = $clog2(SEQ_DEPTH),
  localparam int SGW = $clog2(SEG_DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  output logic [SQW-1:0]   seq_cur,
  input  logic             seq_cur_last,
  output logic [SQW-1:0]   seq_nxt,
  input  logic [SGW-1:0]   nxt_start,
  output logic [SGW-1:0]   seg_addr,
  input  logic [DUR_W-1:0] seg_dur,
  input  logic [1:0]       seg_lvl,
  input  logic             seg_eol,
  output logic [1:0]       level,
  output logic             line_start,
  output logic             frame_start
);

  logic             active_q, active_d;
  logic             first_q, first_d;
  logic [SQW-1:0]   seq_q, seq_d;
  logic [SGW-1:0]   seg_q, seg_d;
  logic [DUR_W-1:0] cnt_q, cnt_d;
  logic             seq_wrap, seg_done;
  lvl_e             lvl_d;
  logic             ls_d, fs_d;

  assign seq_cur  = seq_q;
  assign seg_addr = seg_q;
  assign seq_wrap = seq_cur_last || (seq_q == SQW'(SEQ_DEPTH - 1));
  assign seq_nxt  = (!active_q || seq_wrap) ? '0 : seq_q + SQW'(1);
  assign seg_done = (cnt_q == seg_dur);

  // next state of the table walk
  always_comb begin
    active_d = active_q;
    first_d  = 1'b0;
    seq_d    = seq_q;
    seg_d    = seg_q;
    cnt_d    = cnt_q;
    if (!active_q) begin
      if (run) begin
        active_d = 1'b1;
        first_d  = 1'b1;
        seq_d    = seq_nxt;
        seg_d    = nxt_start;
        cnt_d    = '0;
      end
    end else if (!run) begin
      active_d = 1'b0;
    end else if (seg_done) begin
      cnt_d = '0;
      if (seg_eol) begin
        first_d = 1'b1;
        seq_d   = seq_nxt;
        seg_d   = nxt_start;
      end else begin
        seg_d = seg_q + SGW'(1);
      end
    end else begin
      cnt_d = cnt_q + DUR_W'(1);
    end
  end

  // output codes for the pixel now addressed
  always_comb begin
    lvl_d = active_q ? lvl_e'(seg_lvl) : LVL_ZERO;
    ls_d  = active_q && first_q;
    fs_d  = active_q && first_q && (seq_q == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      first_q  <= 1'b0;
      seq_q    <= '0;
      seg_q    <= '0;
      cnt_q    <= '0;
    end else begin
      active_q <= active_d;
      first_q  <= first_d;
      seq_q    <= seq_d;
      seg_q    <= seg_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level       <= LVL_ZERO;
      line_start  <= 1'b0;
      frame_start <= 1'b0;
    end else begin
      level       <= lvl_d;
      line_start  <= ls_d;
      frame_start <= fs_d;
    end
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && cnt_q != '0) |-> ($past(active_q) && cnt_q == $past(cnt_q) + DUR_W'(1))); // R2

  AST_SEG_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && $past(active_q) && !first_q && seg_q != $past(seg_q))
      |-> seg_q == $past(seg_q) + SGW'(1)); // R3

  AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && $past(active_q) && seq_q != $past(seq_q))
      |-> (seq_q == '0 || seq_q == $past(seq_q) + SQW'(1))); // R4

  AST_FRAME_IN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> line_start); // R5

  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !active_q); // R8

  AST_IDLE_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q |=> (level == LVL_ZERO && !line_start)); // R8

endmodule

// File: rtl/hdsync_seqgen.sv
module hdsync_seqgen
  import hsg_pkg::*;
#(
  parameter int SEQ_DEPTH = 16,
  parameter int TYPE_CNT  = 16,
  parameter int SEG_DEPTH = 32,
  parameter int DUR_W     = 13,
  localparam int SQW = $clog2(SEQ_DEPTH),
  localparam int TYW = $clog2(TYPE_CNT),
  localparam int SGW = $clog2(SEG_DEPTH),
  localparam int SPW = SGW + 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] tbl_sel,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic [1:0] level,
  output logic       line_start,
  output logic       frame_start
);

  logic rst_meta, rst_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  logic [SQW-1:0]   seq_ptr, seq_cur, seq_nxt;
  logic [TYW-1:0]   typ_ptr;
  logic [SPW-1:0]   seg_ptr;
  logic             seq_we, typ_we, seg_we;
  logic             seq_cur_last;
  logic [SGW-1:0]   nxt_start, seg_addr;
  logic [DUR_W-1:0] seg_dur;
  logic [1:0]       seg_lvl;
  logic             seg_eol;

  hsg_wr_ctrl #(
    .SEQ_DEPTH(SEQ_DEPTH), .TYPE_CNT(TYPE_CNT), .SEG_DEPTH(SEG_DEPTH)
  ) u_wr (
    .clk    (clk),
    .rst_n  (rst_sync),
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .sel    (tbl_sel),
    .seq_ptr(seq_ptr),
    .typ_ptr(typ_ptr),
    .seg_ptr(seg_ptr),
    .seq_we (seq_we),
    .typ_we (typ_we),
    .seg_we (seg_we)
  );

  hsg_tables #(
    .SEQ_DEPTH(SEQ_DEPTH), .TYPE_CNT(TYPE_CNT), .SEG_DEPTH(SEG_DEPTH), .DUR_W(DUR_W)
  ) u_tab (
    .clk         (clk),
    .seq_we      (seq_we),
    .typ_we      (typ_we),
    .seg_we      (seg_we),
    .seq_ptr     (seq_ptr),
    .typ_ptr     (typ_ptr),
    .seg_ptr     (seg_ptr),
    .wdata       (wr_data),
    .rd_sel      (tbl_sel),
    .rd_data     (rd_data),
    .seq_cur_addr(seq_cur),
    .seq_cur_last(seq_cur_last),
    .seq_nxt_addr(seq_nxt),
    .nxt_start   (nxt_start),
    .seg_addr    (seg_addr),
    .seg_dur     (seg_dur),
    .seg_lvl     (seg_lvl),
    .seg_eol     (seg_eol)
  );

  hsg_walker #(
    .SEQ_DEPTH(SEQ_DEPTH), .SEG_DEPTH(SEG_DEPTH), .DUR_W(DUR_W)
  ) u_walk (
    .clk         (clk),
    .rst_n       (rst_sync),
    .run         (run),
    .seq_cur     (seq_cur),
    .seq_cur_last(seq_cur_last),
    .seq_nxt     (seq_nxt),
    .nxt_start   (nxt_start),
    .seg_addr    (seg_addr),
    .seg_dur     (seg_dur),
    .seg_lvl     (seg_lvl),
    .seg_eol     (seg_eol),
    .level       (level),
    .line_start  (line_start),
    .frame_start (frame_start)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_sync |=> (!rst_sync || (level == 2'd0 && !frame_start))); // R8

endmodule

// File: tb/tb_hdsync_seqgen.sv
module tb_hdsync_seqgen;

  logic       clk;
  logic       rst_n;
  logic       run;
  logic [1:0] tbl_sel;
  logic       wr_en;
  logic       rd_en;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic [1:0] level;
  logic       line_start;
  logic       frame_start;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  hdsync_seqgen dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .tbl_sel    (tbl_sel),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .level      (level),
    .line_start (line_start),
    .frame_start(frame_start)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {sel[1:0], byte[7:0]} load sequence
  localparam logic [9:0] LOAD_VEC [34] = '{
    10'h000, 10'h005, 10'h00F, 10'h085,
    10'h100, 10'h100, 10'h100, 10'h100, 10'h100, 10'h104, 10'h100, 10'h100,
    10'h100, 10'h100, 10'h100, 10'h100, 10'h100, 10'h100, 10'h100, 10'h106,
    10'h202, 10'h220, 10'h201, 10'h240, 10'h200, 10'h260, 10'h203, 10'h280,
    10'h204, 10'h260, 10'h201, 10'h2A0, 10'h200, 10'h2C0
  };

  // expected frame as runs: {level[1:0], length[7:0], line_start, frame_start}
  localparam logic [11:0] RUN_VEC [9] = '{
    {2'd1, 8'd3, 2'b11}, {2'd2, 8'd2, 2'b00}, {2'd3, 8'd1, 2'b00},
    {2'd0, 8'd4, 2'b00}, {2'd3, 8'd5, 2'b10}, {2'd1, 8'd2, 2'b00},
    {2'd2, 8'd1, 2'b10}, {2'd3, 8'd5, 2'b10}, {2'd1, 8'd2, 2'b00}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    tbl_sel = s; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [1:0] s, input logic [7:0] exp);
    @(negedge clk);
    tbl_sel = s;
    #1;
    chk(req, {24'd0, rd_data}, {24'd0, exp});
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic stop_run();
    @(negedge clk);
    run = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int pix;
    int bad;
    rst_n = 1'b0; run = 1'b0; tbl_sel = 2'd0; wr_en = 1'b0; rd_en = 1'b0; wr_data = 8'h00;
    repeat (3) @(negedge clk);
    chk("R8 reset level", {30'd0, level}, 32'd0);
    chk("R8 reset markers", {30'd0, line_start, frame_start}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // load all tables through the byte port (R6)
    wr(2'd3, 8'h00);
    for (int i = 0; i < 34; i++) wr(LOAD_VEC[i][9:8], LOAD_VEC[i][7:0]);

    // readback after pointer clear (R7)
    wr(2'd3, 8'h00);
    rd_chk("R7 seq entry 0", 2'd0, 8'h00);
    rd_chk("R7 seq entry 1", 2'd0, 8'h05);
    rd_chk("R7 seq entry 2", 2'd0, 8'h0F);
    rd_chk("R7 seq entry 3 last flag", 2'd0, 8'h85);
    rd_chk("R7 seg 0 low byte", 2'd2, 8'h02);
    rd_chk("R7 seg 0 high byte", 2'd2, 8'h20);
    rd_chk("R7 seg 1 low byte", 2'd2, 8'h01);
    wr(2'd3, 8'h00);
    rd_chk("R7 pointer clear", 2'd2, 8'h02);

    // table-driven raster, two frames (R1 R2 R3 R4 R5 R6 R9)
    @(negedge clk);
    run = 1'b1;
    @(negedge clk);
    chk("R9 blank one edge after run", {30'd0, level}, 32'd0);
    for (int f = 0; f < 2; f++) begin
      for (int r = 0; r < 9; r++) begin
        for (int p = 0; p < int'(RUN_VEC[r][9:2]); p++) begin
          @(negedge clk);
          chk($sformatf("R1 R2 R3 level f%0d run%0d px%0d", f, r, p),
              {30'd0, level}, {30'd0, RUN_VEC[r][11:10]});
          chk($sformatf("R5 R4 markers f%0d run%0d px%0d", f, r, p),
              {30'd0, line_start, frame_start},
              {30'd0, RUN_VEC[r][1] && p == 0, RUN_VEC[r][0] && p == 0});
        end
      end
    end
    repeat (4) @(negedge clk);
    run = 1'b0;
    repeat (2) @(negedge clk);
    chk("R8 blank after stop", {30'd0, level, line_start}, 32'd0);

    // restart begins at entry 0 (R8 R9)
    run = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R8 restart level", {30'd0, level}, 32'd1);
    chk("R8 restart frame marker", {30'd0, line_start, frame_start}, 32'd3);
    stop_run();

    // wrap at entry 15 without last flag (R4)
    wr(2'd3, 8'h00);
    for (int i = 0; i < 16; i++) wr(2'd0, 8'h0F);
    @(negedge clk);
    run = 1'b1;
    @(negedge clk);
    bad = 0;
    for (int k = 0; k < 33; k++) begin
      @(negedge clk);
      if (level != 2'd2 || !line_start || frame_start != (k % 16 == 0)) bad++;
    end
    chk("R4 wrap after entry 15", bad, 0);
    stop_run();

    // long segment using duration upper bits (R2), single-entry frame (R4)
    wr(2'd3, 8'h00);
    wr(2'd0, 8'h80);
    wr(2'd3, 8'h00);
    wr(2'd2, 8'h05);
    wr(2'd2, 8'h21);
    @(negedge clk);
    run = 1'b1;
    @(negedge clk);
    bad = 0;
    pix = 0;
    for (int k = 0; k < 270; k++) begin
      @(negedge clk);
      if (k < 262 && level != 2'd1) bad++;
      if (k == 262) chk("R2 long segment ends after 262 pixels", {30'd0, level}, 32'd2);
      if (k == 268) chk("R3 line tail blank", {30'd0, level}, 32'd0);
      if (k == 269) begin
        chk("R4 single-entry frame restarts", {30'd0, line_start, frame_start}, 32'd3);
        chk("R1 level after wrap", {30'd0, level}, 32'd1);
      end
      pix++;
    end
    chk("R2 long segment held", bad, 0);
    chk("R2 pixels walked", pix, 270);
    stop_run();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule